// File: doc/BRIEF.md
# Continuous memory CRC error monitor

This block watches a configuration memory for silent corruption. Once initialization is over, it reads the memory one 32-bit word at a time through a read port that answers in the same cycle. It folds every word into a 32-bit CRC engine. The engine starts each pass from an expected value held in a storage register. With intact contents and a matching expected value, the engine ends the pass at exactly zero. That end value is copied into a signature register, and the error flag is derived from it. Passes follow one another back to back until reset.

The checking rate is set by a programmable divider: only cycles on which the divider ticks advance a pass. The storage register can also act as a 32-bit serial shift chain while checking continues. Shifting a different value into it is how a test forces the flag high on purpose.

The control is a four-state machine. IDLE waits for `init_done`; the transition IDLE to SEED captures `exp_sig` into the storage register. SEED copies the storage register into the engine on a tick and moves to WALK. WALK folds one word per tick and moves to FINISH after the last address. FINISH publishes the result on a tick and returns to SEED.

Top module: `cfg_crc_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until checking starts, the outputs hold these values: `crc_err` is 0, `signature` is 0, `pass_done` is 0, `mem_addr` is 0, and the storage register is 0, so `scan_out` is 0.
- R2: In IDLE, a high `init_done` captures `exp_sig` into the storage register and starts checking; this does not wait for a divider tick. From then on, passes repeat with no further input until reset, and `init_done` is ignored.
- R3: A pass is one SEED tick, then DEPTH WALK ticks, then one FINISH tick, so it takes DEPTH+2 ticks. The WALK ticks read addresses 0 up to DEPTH-1 in ascending order. The next SEED tick is the tick right after FINISH.
- R4: The engine uses polynomial 0x04C11DB7 and takes data word bit 31 first. It applies no input reflection and no final inversion. A pass starts from the seed latched at SEED. Intact data with the matching expected value gives a signature of 0.
- R5: `crc_err` equals "signature is non-zero" and changes only at the end of a pass. It holds its value through the whole following pass and depends on the latest completed pass alone.
- R6: `pass_done` is a one-cycle pulse in the first cycle that shows the updated `signature` and `crc_err`.
- R7: The divider ticks once every `div_sel`+1 clock cycles, so a pass takes (DEPTH+2)·(`div_sel`+1) cycles. `mem_addr` changes only after a tick.
- R8: While `scan_en` is high, the storage register shifts one place toward bit 31 on each clock. `scan_in` enters bit 0, and `scan_out` always shows bit 31. Checking keeps running during the shift.
- R9: A shift during a pass affects only later passes. If a shift and the SEED tick fall in the same cycle, the engine takes the value from before the shift.
- R10: In IDLE, the capture of `exp_sig` wins over a shift requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator side of the divider) |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | High when initialization is over; starts checking |
| exp_sig | input | 32 | Precomputed expected value, captured at start |
| div_sel | input | DIV_W | Divisor: tick every div_sel+1 cycles |
| mem_addr | output | ADDR_W | Memory word address being read |
| mem_rdata | input | 32 | Word at mem_addr, same cycle |
| scan_en | input | 1 | Storage register shifts when high |
| scan_in | input | 1 | Serial input into storage bit 0 |
| scan_out | output | 1 | Storage register bit 31 |
| signature | output | 32 | Result of the latest completed pass |
| crc_err | output | 1 | Non-zero result in the latest completed pass |
| pass_done | output | 1 | One-cycle pulse on each signature update |

## Verification
Two functions can act in the same cycle on the same storage register. The first is the serial shift; the second is either the seed copy into the engine or, in IDLE, the capture of `exp_sig`. The bench provokes the shift/seed case by rotating the storage register through itself for 32 clocks at the fastest rate, so several SEED ticks land inside the shifting window. It provokes the IDLE case by raising `scan_en` in the same cycle that `init_done` starts checking. A behavioural model checks the outcome every clock. It applies the pre-edge storage value to the seed and gives the capture priority, and each pass's signature and flag are compared cycle by cycle against that model.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;

    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEED   = 2'd1,
        ST_WALK   = 2'd2,
        ST_FINISH = 2'd3
    } mon_state_t;

    // One word folded into the running value, bit 31 first.
    function automatic logic [CRC_W-1:0] crc_fold(
        input logic [CRC_W-1:0] acc,
        input logic [CRC_W-1:0] word
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = acc;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ word[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_tick_div.sv
module crc_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q >= div_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_sel != '0) ##1 $stable(div_sel) |-> !tick);

endmodule

// File: rtl/crc_seed_store.sv
module crc_seed_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] q,
    output logic         shift_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[W-2:0], shift_in};
        end
    end

    assign shift_out = q[W-1];

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load) |=> $stable(q));

endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine
    import crc_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_en,
    input  logic [CRC_W-1:0] seed_val,
    input  logic             fold_en,
    input  logic [CRC_W-1:0] word,
    output logic [CRC_W-1:0] acc
);

    logic [CRC_W-1:0] acc_d;

    always_comb begin
        acc_d = acc;
        if (seed_en) begin
            acc_d = seed_val;
        end else if (fold_en) begin
            acc_d = crc_fold(acc, word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc_d;
        end
    end

    // R9
    engine_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_en && !fold_en) |=> $stable(acc));

endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor
    import crc_mon_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int DIV_W  = 8,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_done,
    input  logic [CRC_W-1:0]  exp_sig,
    input  logic [DIV_W-1:0]  div_sel,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [CRC_W-1:0]  mem_rdata,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    output logic [CRC_W-1:0]  signature,
    output logic              crc_err,
    output logic              pass_done
);

    mon_state_t       state_q, state_d;
    logic             tick;
    logic             last_addr;
    logic             cap_sig, seed_en, fold_en, finish;
    logic [CRC_W-1:0] stored;
    logic [CRC_W-1:0] acc;

    crc_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick)
    );

    crc_seed_store #(.W(CRC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_sig),
        .load_val  (exp_sig),
        .shift_en  (scan_en),
        .shift_in  (scan_in),
        .q         (stored),
        .shift_out (scan_out)
    );

    crc_fold_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_en  (seed_en),
        .seed_val (stored),
        .fold_en  (fold_en),
        .word     (mem_rdata),
        .acc      (acc)
    );

    assign last_addr = (mem_addr == ADDR_W'(DEPTH - 1));
    assign cap_sig   = (state_q == ST_IDLE) && init_done;
    assign seed_en   = (state_q == ST_SEED) && tick;
    assign fold_en   = (state_q == ST_WALK) && tick;
    assign finish    = (state_q == ST_FINISH) && tick;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (init_done)         state_d = ST_SEED;
            ST_SEED:   if (tick)              state_d = ST_WALK;
            ST_WALK:   if (tick && last_addr) state_d = ST_FINISH;
            ST_FINISH: if (tick)              state_d = ST_SEED;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address and result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            signature <= '0;
            crc_err   <= 1'b0;
            pass_done <= 1'b0;
        end else begin
            pass_done <= finish;
            if (seed_en) begin
                mem_addr <= '0;
            end else if (fold_en && !last_addr) begin
                mem_addr <= mem_addr + 1'b1;
            end
            if (finish) begin
                signature <= acc;
                crc_err   <= |acc;
            end
        end
    end

    // R5
    err_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err != $past(crc_err)) |-> pass_done);

    // R5
    err_matches_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err == (signature != '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R2
    no_return_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

    // R7
    addr_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mem_addr));

endmodule

// File: tb/cfg_crc_monitor_tb.sv
module cfg_crc_monitor_tb;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam logic [31:0] GEN = 32'h04C1_1DB7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          init_done;
    logic [31:0]   exp_sig;
    logic [7:0]    div_sel;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          scan_en, scan_in, scan_out;
    logic [31:0]   signature;
    logic          crc_err, pass_done;

    logic [31:0] mem [DEPTH];
    assign mem_rdata = mem[mem_addr];

    always #4 clk = ~clk;

    cfg_crc_monitor #(.DEPTH(DEPTH), .DIV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .exp_sig(exp_sig),
        .div_sel(div_sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
        .signature(signature), .crc_err(crc_err), .pass_done(pass_done)
    );

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit model_ok = 1'b0;
    bit ended = 1'b0;

    function automatic logic [31:0] fold(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ GEN;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] unfold_zero(input logic [31:0] c);
        logic [31:0] t = c[0] ? (c ^ GEN) : c;
        return {c[0], t[31:1]};
    endfunction

    function automatic logic [31:0] expected_for_mem();
        logic [31:0] t = '0;
        for (int i = 0; i < DEPTH; i++) t = fold(t, mem[i]);
        for (int k = 0; k < 32 * DEPTH; k++) t = unfold_zero(t);
        return t;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase -1 idle, 0 seed, 1..DEPTH walk, DEPTH+1 finish
    int          m_phase, m_addr, m_wait;
    logic [31:0] m_crc, m_store, m_sig, pre_store;
    bit          m_err, m_done, t_now, was_idle;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = -1; m_addr = 0; m_wait = 0; m_crc = '0;
            m_store = '0; m_sig = '0; m_err = 0; m_done = 0;
            model_ok = 1'b1;
        end else begin
            pre_store = m_store;
            was_idle  = (m_phase == -1);
            t_now     = (m_wait >= int'(div_sel));
            m_wait    = t_now ? 0 : m_wait + 1;
            m_done    = 0;
            if (was_idle) begin
                if (init_done) m_phase = 0;
            end else if (t_now) begin
                if (m_phase == 0) begin
                    m_crc = pre_store; m_addr = 0; m_phase = 1;
                end else if (m_phase <= DEPTH) begin
                    m_crc = fold(m_crc, mem[m_addr]);
                    if (m_phase == DEPTH) m_phase = DEPTH + 1;
                    else begin m_phase++; m_addr++; end
                end else begin
                    m_sig = m_crc; m_err = (m_crc != 0); m_done = 1; m_phase = 0;
                end
            end
            if (was_idle && init_done) m_store = exp_sig;      // R10 capture first
            else if (scan_en)          m_store = {pre_store[30:0], scan_in};
        end
    end

    always @(negedge clk) begin
        if (model_ok && !ended) begin
            chk("R5 crc_err vs model", {31'b0, crc_err}, {31'b0, m_err});
            chk("R6 pass_done vs model", {31'b0, pass_done}, {31'b0, m_done});
            chk("R4 signature vs model", signature, m_sig);
            chk("R3 mem_addr vs model", {28'b0, mem_addr}, 32'(m_addr));
            chk("R8 scan_out vs model", {31'b0, scan_out}, {31'b0, m_store[31]});
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !ended) begin
            miscompares++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<=20000", cycles);
            finish_run();
        end
    end

    task automatic wait_pass(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!pass_done);
    endtask

    task automatic shift_word(input logic [31:0] v);
        scan_en = 1'b1;
        for (int i = 31; i >= 0; i--) begin
            scan_in = v[i];
            @(negedge clk);
        end
        scan_en = 1'b0;
    endtask

    logic [31:0] good;
    int n;

    initial begin
        rst_n = 1'b0; init_done = 1'b0; exp_sig = '0; div_sel = '0;
        scan_en = 1'b0; scan_in = 1'b0;
        for (int i = 0; i < DEPTH; i++) mem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
        good = expected_for_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: idle after reset, nothing moves without init_done
        chk("R1 crc_err idle", {31'b0, crc_err}, 0);
        chk("R1 signature idle", signature, 0);
        chk("R1 mem_addr idle", {28'b0, mem_addr}, 0);
        chk("R1 scan_out idle", {31'b0, scan_out}, 0);

        // R2: start, then drop init_done; passes keep going
        exp_sig = good; init_done = 1'b1;
        @(negedge clk);
        init_done = 1'b0; exp_sig = ~good;
        wait_pass(n);
        chk("R4 clean signature zero", signature, 0);
        wait_pass(n);
        chk("R3 pass length div0", 32'(n), 32'(DEPTH + 2));
        chk("R2 init_done ignored, still clean", {31'b0, crc_err}, 0);

        // R5: corruption, hold through next pass, clear when clean
        mem[5] = mem[5] ^ 32'h0000_0010;
        wait_pass(n);
        chk("R5 corrupted pass sets flag", {31'b0, crc_err}, 1);
        mem[5] = mem[5] ^ 32'h0000_0010;
        repeat (8) @(negedge clk);
        chk("R5 flag held mid pass", {31'b0, crc_err}, 1);
        wait_pass(n);
        chk("R5 clean pass clears flag", {31'b0, crc_err}, 0);

        // R7: slower rate
        div_sel = 8'd3;
        wait_pass(n);
        wait_pass(n);
        chk("R7 pass length div3", 32'(n), 32'((DEPTH + 2) * 4));

        // R9 / R8: inject mid pass, effect only on the next pass
        repeat (8) @(negedge clk);
        shift_word(good ^ 32'h1);
        wait_pass(n);
        chk("R9 current pass keeps latched seed", {31'b0, crc_err}, 0);
        wait_pass(n);
        chk("R8 injected seed flags error", {31'b0, crc_err}, 1);
        repeat (8) @(negedge clk);
        shift_word(good);
        wait_pass(n);
        chk("R9 pass seeded before restore", {31'b0, crc_err}, 1);
        wait_pass(n);
        chk("R8 restored seed clean", {31'b0, crc_err}, 0);

        // R9: rotate storage through itself across several SEED ticks
        div_sel = 8'd0;
        wait_pass(n);
        scan_en = 1'b1;
        repeat (32) begin
            scan_in = scan_out;
            @(negedge clk);
        end
        scan_en = 1'b0;
        wait_pass(n);
        wait_pass(n);
        chk("R9 rotation restores storage", {31'b0, crc_err}, 0);

        // R1 again from an error state, then R10 capture vs shift
        mem[0] = ~mem[0];
        wait_pass(n);
        wait_pass(n);
        chk("R5 flag before reset", {31'b0, crc_err}, 1);
        rst_n = 1'b0;
        mem[0] = ~mem[0];
        @(negedge clk);
        chk("R1 crc_err in reset", {31'b0, crc_err}, 0);
        chk("R1 signature in reset", signature, 0);
        chk("R1 pass_done in reset", {31'b0, pass_done}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1; init_done = 1'b1; exp_sig = good;
        scan_en = 1'b1; scan_in = 1'b1;
        @(negedge clk);
        scan_en = 1'b0; init_done = 1'b0;
        chk("R10 capture wins over shift", {31'b0, scan_out}, {31'b0, good[31]});
        wait_pass(n);
        chk("R10 captured seed clean", {31'b0, crc_err}, 0);
        chk("R4 signature zero after restart", signature, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule